// File: doc/BRIEF.md
# Two-Queue Weighted Round-Robin Transmit Scheduler

This block sits beside each output port's transmit path. Every port keeps two packet queues: an urgent (high) one and a bulk (low) one. Whenever the MAC signals that a transmit slot is free, the scheduler picks one queue and issues a grant that names it. When both queues hold packets, it grants the high queue a programmable number of times and then grants the low queue once, and the cycle repeats. The high-queue share is set by a 4-bit weight from 1 to 15, and a weight of 0 is treated as 1.

The grant is made per packet. It stays asserted until the MAC acknowledges the end of that packet, and only after that acknowledge can a new decision be taken. A credit counter records how many high grants have gone out since the last low grant. It is kept across packets and across idle gaps, so the ratio holds even when slots arrive sparsely. If only one queue has work, that queue wins every slot, whatever the counter says.

Top module: `wrr2_sched`

## Requirements
- R1: After reset no grant is asserted and the credit counter is zero, so the first contested slots follow the full weight pattern from its start.
- R2: When no grant is pending, a slot strobe with at least one queue non-empty raises `grant_vld` on the next clock edge. A slot strobe with both queues empty raises no grant.
- R3: A grant and its queue select stay constant until `pkt_done` is seen. `grant_vld` falls on the edge that samples `pkt_done`. Slot strobes and changes to the queue flags while a grant is pending have no effect.
- R4: With both queues non-empty and weight W (1..15), the grants follow the pattern of W grants with `grant_lo`=0 (high queue) and then one grant with `grant_lo`=1 (low queue), repeating.
- R5: A weight value of 0 gives the same pattern as a weight of 1: high and low alternate.
- R6: When only the high queue is non-empty, every slot grants the high queue.
- R7: When only the low queue is non-empty, every slot grants the low queue, and any low grant clears the credit counter.
- R8: If a low grant is due and the low queue is empty, the high queue is granted and the credit counter is cleared. W further high grants then come before the next low grant.
- R9: The credit counter changes only when a grant is issued, so idle gaps between slots do not disturb the pattern.
- R10: The largest weight, 15, gives fifteen high grants before each low grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_nonempty | input | 1 | High-priority queue holds at least one packet |
| lo_nonempty | input | 1 | Low-priority queue holds at least one packet |
| hi_weight | input | 4 | High grants per low grant; 0 acts as 1 |
| slot_avail | input | 1 | Pulse: MAC can accept a new packet |
| pkt_done | input | 1 | End-of-packet acknowledge for the pending grant |
| grant_vld | output | 1 | A grant is pending |
| grant_lo | output | 1 | Queue granted: 0 = high, 1 = low |

## Verification
A decision is registered, so `grant_vld` and `grant_lo` become valid one edge after the slot strobe is sampled. `grant_vld` falls one edge after `pkt_done` is sampled. The bench drives every input on the falling edge and samples the outputs on the next falling edge, which is exactly one rising edge after the stimulus. During the hold-off check it samples on every falling edge for several cycles. Every weight pattern is built as a chain of these one-edge slot/acknowledge exchanges. The expected queue for each exchange is computed in the bench from the weight and a model counter.

// File: rtl/wrr2_pkg.sv
package wrr2_pkg;
  typedef enum logic {
    QSEL_HI = 1'b0,
    QSEL_LO = 1'b1
  } qsel_e;

  typedef enum logic {
    GST_IDLE = 1'b0,
    GST_BUSY = 1'b1
  } gst_e;
endpackage

// File: rtl/wrr2_pick.sv
module wrr2_pick
  import wrr2_pkg::*;
#(
  parameter int WGT_W = 4
) (
  input  logic             hi_ne,
  input  logic             lo_ne,
  input  logic [WGT_W-1:0] weight,
  input  logic [WGT_W-1:0] cnt,
  output logic             any_ne,
  output qsel_e            pick,
  output logic [WGT_W-1:0] cnt_nxt
);
  localparam logic [WGT_W-1:0] ONE = WGT_W'(1);

  logic [WGT_W-1:0] eff_w;
  logic             lo_due;

  always_comb begin
    eff_w   = (weight == '0) ? ONE : weight;
    lo_due  = (cnt >= eff_w);
    any_ne  = hi_ne | lo_ne;
    pick    = QSEL_HI;
    cnt_nxt = cnt;
    if (hi_ne && lo_ne) begin
      if (lo_due) begin
        pick    = QSEL_LO;
        cnt_nxt = '0;
      end else begin
        pick    = QSEL_HI;
        cnt_nxt = cnt + ONE;
      end
    end else if (hi_ne) begin
      pick    = QSEL_HI;
      cnt_nxt = lo_due ? '0 : (cnt + ONE);
    end else if (lo_ne) begin
      pick    = QSEL_LO;
      cnt_nxt = '0;
    end
  end
endmodule

// File: rtl/wrr2_credit.sv
module wrr2_credit #(
  parameter int WGT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [WGT_W-1:0] cnt_nxt,
  output logic [WGT_W-1:0] cnt
);
  logic [WGT_W-1:0] cnt_q;
  logic [WGT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = take;
    cnt_d  = cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  AST_CNT_HOLDS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/wrr2_sched.sv
module wrr2_sched
  import wrr2_pkg::*;
#(
  parameter int WGT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_nonempty,
  input  logic             lo_nonempty,
  input  logic [WGT_W-1:0] hi_weight,
  input  logic             slot_avail,
  input  logic             pkt_done,
  output logic             grant_vld,
  output logic             grant_lo
);
  gst_e             st_q, st_d;
  qsel_e            sel_q, sel_d;
  qsel_e            pick;
  logic             any_ne;
  logic             take;
  logic             st_en;
  logic             sel_en;
  logic [WGT_W-1:0] cnt;
  logic [WGT_W-1:0] cnt_nxt;

  wrr2_pick #(.WGT_W(WGT_W)) u_pick (
    .hi_ne   (hi_nonempty),
    .lo_ne   (lo_nonempty),
    .weight  (hi_weight),
    .cnt     (cnt),
    .any_ne  (any_ne),
    .pick    (pick),
    .cnt_nxt (cnt_nxt)
  );

  wrr2_credit #(.WGT_W(WGT_W)) u_credit (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .cnt_nxt (cnt_nxt),
    .cnt     (cnt)
  );

  always_comb begin
    take   = (st_q == GST_IDLE) && slot_avail && any_ne;
    st_d   = st_q;
    sel_d  = sel_q;
    st_en  = 1'b0;
    sel_en = 1'b0;
    unique case (st_q)
      GST_IDLE: begin
        if (take) begin
          st_d   = GST_BUSY;
          sel_d  = pick;
          st_en  = 1'b1;
          sel_en = 1'b1;
        end
      end
      GST_BUSY: begin
        if (pkt_done) begin
          st_d  = GST_IDLE;
          st_en = 1'b1;
        end
      end
      default: begin
        st_d  = GST_IDLE;
        st_en = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= GST_IDLE;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= QSEL_HI;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  assign grant_vld = (st_q == GST_BUSY);
  assign grant_lo  = (sel_q == QSEL_LO);

  AST_SLOT_GIVES_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld && slot_avail && (hi_nonempty || lo_nonempty)) |=> grant_vld); // R2
  AST_NO_WORK_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld && !(slot_avail && (hi_nonempty || lo_nonempty))) |=> !grant_vld); // R2
  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && !pkt_done) |=> (grant_vld && $stable(grant_lo))); // R3
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && pkt_done) |=> !grant_vld); // R3
  AST_HI_ONLY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld && slot_avail && hi_nonempty && !lo_nonempty) |=> !grant_lo); // R6
  AST_LO_ONLY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld && slot_avail && !hi_nonempty && lo_nonempty) |=> grant_lo); // R7
  AST_LO_CLEARS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_vld) && grant_lo |-> (cnt == '0)); // R7
endmodule

// File: tb/wrr2_sched_bench.sv
module wrr2_sched_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYC = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hi_nonempty, lo_nonempty, slot_avail, pkt_done;
  logic [3:0] hi_weight;
  logic       grant_vld, grant_lo;

  int n_chk = 0;
  int n_bad = 0;
  int model_cnt = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrr2_sched u_wrr2_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .hi_nonempty (hi_nonempty),
    .lo_nonempty (lo_nonempty),
    .hi_weight   (hi_weight),
    .slot_avail  (slot_avail),
    .pkt_done    (pkt_done),
    .grant_vld   (grant_vld),
    .grant_lo    (grant_lo)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // model of the pick, from the requirements
  function automatic logic model_pick(input logic h, input logic l, input int w);
    int ew = (w == 0) ? 1 : w;
    logic due = (model_cnt >= ew);
    if (h && l) begin
      if (due) begin model_cnt = 0; return 1'b1; end
      model_cnt++; return 1'b0;
    end else if (h) begin
      if (due) model_cnt = 0; else model_cnt++;
      return 1'b0;
    end
    model_cnt = 0;
    return 1'b1;
  endfunction

  // one slot/ack exchange; inputs change on the falling edge
  task automatic slot(input string req, input logic h, input logic l);
    logic exp_lo;
    hi_nonempty = h; lo_nonempty = l; slot_avail = 1'b1;
    exp_lo = model_pick(h, l, int'(hi_weight));
    @(negedge clk);
    slot_avail = 1'b0;
    check({req, " grant_vld"}, grant_vld, 1'b1);
    check({req, " grant_lo"}, grant_lo, exp_lo);
    pkt_done = 1'b1;
    @(negedge clk);
    pkt_done = 1'b0;
    check({req, " release"}, grant_vld, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 reset no grant", grant_vld, 1'b0);
    model_cnt = 0;
    hi_weight = 4'd4;
    for (int k = 0; k < 10; k++) slot("R1 R4 w4 from reset", 1'b1, 1'b1);
  endtask

  task automatic t_empty_slot();
    hi_nonempty = 1'b0; lo_nonempty = 1'b0; slot_avail = 1'b1;
    @(negedge clk);
    slot_avail = 1'b0;
    check("R2 empty slot no grant", grant_vld, 1'b0);
    @(negedge clk);
    check("R2 still idle", grant_vld, 1'b0);
  endtask

  task automatic t_hold();
    hi_weight = 4'd3;
    slot("R7 clear credit", 1'b0, 1'b1);
    hi_nonempty = 1'b1; lo_nonempty = 1'b1; slot_avail = 1'b1;
    @(negedge clk);
    model_cnt = 1;
    check("R2 grant next edge", grant_vld, 1'b1);
    check("R3 first is high", grant_lo, 1'b0);
    for (int k = 0; k < 4; k++) begin
      slot_avail = 1'b1;
      hi_nonempty = k[0]; lo_nonempty = 1'b1;
      @(negedge clk);
      check("R3 held vld", grant_vld, 1'b1);
      check("R3 held sel", grant_lo, 1'b0);
    end
    slot_avail = 1'b0; pkt_done = 1'b1;
    @(negedge clk);
    pkt_done = 1'b0;
    check("R3 release after done", grant_vld, 1'b0);
    // credit advanced only once: two more highs then low
    for (int k = 0; k < 4; k++) slot("R3 R4 w3 after hold", 1'b1, 1'b1);
  endtask

  task automatic t_weight(input string req, input logic [3:0] w, input int n);
    hi_weight = w;
    slot({req, " clear"}, 1'b0, 1'b1);
    for (int k = 0; k < n; k++) slot(req, 1'b1, 1'b1);
  endtask

  task automatic t_single();
    hi_weight = 4'd1;
    for (int k = 0; k < 5; k++) slot("R6 high only", 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) slot("R7 low only", 1'b0, 1'b1);
    slot("R7 cleared credit high", 1'b1, 1'b1);
    slot("R7 cleared credit low", 1'b1, 1'b1);
  endtask

  task automatic t_lo_missing();
    hi_weight = 4'd2;
    slot("R8 clear", 1'b0, 1'b1);
    slot("R8 h", 1'b1, 1'b1);
    slot("R8 h", 1'b1, 1'b1);
    slot("R8 low due but empty", 1'b1, 1'b0);
    slot("R8 after reset h1", 1'b1, 1'b1);
    slot("R8 after reset h2", 1'b1, 1'b1);
    slot("R8 then low", 1'b1, 1'b1);
  endtask

  task automatic t_gap();
    hi_weight = 4'd3;
    slot("R9 clear", 1'b0, 1'b1);
    slot("R9 h", 1'b1, 1'b1);
    hi_nonempty = 1'b1; lo_nonempty = 1'b1;
    repeat (10) @(negedge clk);
    check("R9 idle no grant", grant_vld, 1'b0);
    for (int k = 0; k < 3; k++) slot("R9 after gap", 1'b1, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; hi_nonempty = 1'b0; lo_nonempty = 1'b0;
    slot_avail = 1'b0; pkt_done = 1'b0; hi_weight = 4'd4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty_slot();
    t_hold();
    t_weight("R5 w0", 4'd0, 8);
    t_weight("R4 w2", 4'd2, 9);
    t_weight("R10 w15", 4'd15, 34);
    t_single();
    t_lo_missing();
    t_gap();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule